// File: doc/BRIEF.md
# Pipelined Ternary-Tree Population Counter

This block counts the set bits of a wide input word. The word is split into small granules whose ones are counted combinationally. A chain of registered stages follows, and each stage adds partial sums in groups of three until a single total remains. The word is widened with zeros to the granule width times a power of three, so that every stage has exactly three operands per adder. A valid flag travels through a delay line of matching depth, so the output valid and the output sum always refer to the same input word.

The block accepts a new word on every clock cycle and never stalls. The input width and the granule width are parameters. The number of registered stages is derived from them: it is the smallest depth of at least one for which the granule width times three to that depth covers the input width.

Top module: `popcnt_tree`

## Requirements
- R1: When `valid_o` is high, `sum_o` equals the number of ones in the `vec_i` word that was presented with `valid_i` high DEPTH cycles earlier.
- R2: DEPTH is the smallest integer d >= 1 with GRANULE_WIDTH * 3^d >= VECTOR_WIDTH. With GRANULE_WIDTH = 6, this gives 1 for an 8-bit word, 2 for a 20-bit word and 3 for a 128-bit word.
- R3: `valid_o` is high exactly DEPTH cycles after each cycle in which `valid_i` is high at a rising clock edge, and low in all other cycles.
- R4: A new word is accepted on every cycle. Back-to-back valid inputs each produce their own result on consecutive cycles, in input order.
- R5: The zero padding does not change the result. An all-ones word yields exactly VECTOR_WIDTH, an all-zeros word yields 0, and the result never exceeds VECTOR_WIDTH.
- R6: While `rst_ni` is low, `valid_o` is 0 and `sum_o` is 0.
- R7: `sum_o` is $clog2(VECTOR_WIDTH+1) bits wide and is an unsigned binary count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Marks `vec_i` as a word to count |
| vec_i | input | VECTOR_WIDTH | Word whose set bits are counted |
| valid_o | output | 1 | `sum_o` holds a result |
| sum_o | output | $clog2(VECTOR_WIDTH+1) | Number of ones in the matching input word |

## Verification
Every result is due DEPTH rising edges after the edge that captured its word. For the 8-bit, 20-bit and 128-bit instances this is one, two and three edges. The driver stamps each expected count with its due cycle as it pushes the count into a per-instance queue. The monitor samples on the falling edge and checks both the value and the cycle of each `valid_o` pulse against the head of the queue. A missing pulse, an early pulse or an unexpected pulse therefore each show up as a failure.

// File: rtl/popcnt_pkg.sv
package popcnt_pkg;

  function automatic int pow3(input int e);
    int r;
    r = 1;
    for (int i = 0; i < e; i++) r = r * 3;
    return r;
  endfunction

  // smallest d >= 1 with gw * 3^d >= vw
  function automatic int tree_depth(input int vw, input int gw);
    int d;
    d = 1;
    while (gw * pow3(d) < vw) d++;
    return d;
  endfunction

  // bits needed for a partial sum at level l (level 0 = granule counts)
  function automatic int lvl_width(input int gw, input int l);
    return $clog2(gw * pow3(l) + 1);
  endfunction

  // bit offset of level l inside the flat tree bus
  function automatic int lvl_offset(input int gw, input int d, input int l);
    int o;
    o = 0;
    for (int k = 0; k < l; k++) o = o + pow3(d - k) * lvl_width(gw, k);
    return o;
  endfunction

endpackage

// File: rtl/popcnt_granule.sv
module popcnt_granule #(
  parameter int GRAN_W = 6,
  parameter int CNT_W  = $clog2(GRAN_W + 1)
) (
  input  logic [GRAN_W-1:0] bits_i,
  output logic [CNT_W-1:0]  cnt_o
);

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < GRAN_W; i++) cnt_o = cnt_o + CNT_W'(bits_i[i]);
  end

endmodule

// File: rtl/popcnt_level.sv
module popcnt_level #(
  parameter int N_OUT = 1,
  parameter int IN_W  = 3,
  parameter int OUT_W = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [3*N_OUT*IN_W-1:0] in_i,
  output logic [N_OUT*OUT_W-1:0]  sum_o
);

  logic [N_OUT*OUT_W-1:0] sum_d;

  for (genvar j = 0; j < N_OUT; j++) begin : g_add
    assign sum_d[j*OUT_W +: OUT_W] = OUT_W'(in_i[(3*j+0)*IN_W +: IN_W])
                                   + OUT_W'(in_i[(3*j+1)*IN_W +: IN_W])
                                   + OUT_W'(in_i[(3*j+2)*IN_W +: IN_W]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_o <= '0;
    else         sum_o <= sum_d;
  end

  // total count is conserved from one level to the next
  int in_total, out_total;
  always_comb begin
    in_total = 0;
    for (int k = 0; k < 3*N_OUT; k++) in_total = in_total + 32'(in_i[k*IN_W +: IN_W]);
    out_total = 0;
    for (int k = 0; k < N_OUT; k++) out_total = out_total + 32'(sum_o[k*OUT_W +: OUT_W]);
  end

  AST_LEVEL_CONSERVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> out_total == $past(in_total)); // R1

endmodule

// File: rtl/popcnt_vdelay.sv
module popcnt_vdelay #(
  parameter int DEPTH = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic valid_o
);

  logic [DEPTH-1:0] vq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vq <= '0;
    end else begin
      vq[0] <= valid_i;
      for (int i = 1; i < DEPTH; i++) vq[i] <= vq[i-1];
    end
  end

  assign valid_o = vq[DEPTH-1];

  AST_VALID_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> vq[0] == $past(valid_i)); // R3

endmodule

// File: rtl/popcnt_tree.sv
module popcnt_tree
  import popcnt_pkg::*;
#(
  parameter int VECTOR_WIDTH  = 128,
  parameter int GRANULE_WIDTH = 6,
  localparam int SUM_W        = $clog2(VECTOR_WIDTH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [VECTOR_WIDTH-1:0] vec_i,
  output logic                    valid_o,
  output logic [SUM_W-1:0]        sum_o
);

  localparam int DEPTH     = tree_depth(VECTOR_WIDTH, GRANULE_WIDTH);
  localparam int N_GRAN    = pow3(DEPTH);
  localparam int PAD_W     = GRANULE_WIDTH * N_GRAN;
  localparam int GRAN_CW   = lvl_width(GRANULE_WIDTH, 0);
  localparam int TREE_W    = lvl_offset(GRANULE_WIDTH, DEPTH, DEPTH + 1);
  localparam int FINAL_W   = lvl_width(GRANULE_WIDTH, DEPTH);
  localparam int FINAL_OFF = lvl_offset(GRANULE_WIDTH, DEPTH, DEPTH);

  logic [PAD_W-1:0]   vec_pad;
  logic [TREE_W-1:0]  tree;
  logic [FINAL_W-1:0] total;

  assign vec_pad = PAD_W'(vec_i);

  // level 0: combinational granule counters
  for (genvar g = 0; g < N_GRAN; g++) begin : g_gran
    popcnt_granule #(
      .GRAN_W (GRANULE_WIDTH),
      .CNT_W  (GRAN_CW)
    ) u_gran (
      .bits_i (vec_pad[g*GRANULE_WIDTH +: GRANULE_WIDTH]),
      .cnt_o  (tree[g*GRAN_CW +: GRAN_CW])
    );
  end

  // levels 1..DEPTH: registered 3-input adders
  for (genvar l = 1; l <= DEPTH; l++) begin : g_lvl
    localparam int N_O  = pow3(DEPTH - l);
    localparam int I_W  = lvl_width(GRANULE_WIDTH, l - 1);
    localparam int O_W  = lvl_width(GRANULE_WIDTH, l);
    localparam int I_OF = lvl_offset(GRANULE_WIDTH, DEPTH, l - 1);
    localparam int O_OF = lvl_offset(GRANULE_WIDTH, DEPTH, l);
    popcnt_level #(
      .N_OUT (N_O),
      .IN_W  (I_W),
      .OUT_W (O_W)
    ) u_lvl (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .in_i   (tree[I_OF +: 3*N_O*I_W]),
      .sum_o  (tree[O_OF +: N_O*O_W])
    );
  end

  popcnt_vdelay #(
    .DEPTH (DEPTH)
  ) u_vdelay (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .valid_o (valid_o)
  );

  assign total = tree[FINAL_OFF +: FINAL_W];
  assign sum_o = total[SUM_W-1:0];

  AST_SUM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(total) <= VECTOR_WIDTH); // R5

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && sum_o == '0)); // R6

endmodule

// File: tb/popcnt_tree_tb.sv
`timescale 1ns/1ps
module popcnt_tree_tb;

  typedef struct {
    int  cnt;
    int  due;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [127:0] vec = '0;

  logic       v128, v8, v20;
  logic [7:0] s128;
  logic [3:0] s8;
  logic [4:0] s20;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  item_t q128[$], q8[$], q20[$];

  // expected latencies from R2
  localparam int LAT128 = 3;
  localparam int LAT8   = 1;
  localparam int LAT20  = 2;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  popcnt_tree #(.VECTOR_WIDTH(128), .GRANULE_WIDTH(6)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .vec_i(vec),
    .valid_o(v128), .sum_o(s128));

  popcnt_tree #(.VECTOR_WIDTH(8), .GRANULE_WIDTH(6)) u_dut_w8 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .vec_i(vec[7:0]),
    .valid_o(v8), .sum_o(s8));

  popcnt_tree #(.VECTOR_WIDTH(20), .GRANULE_WIDTH(6)) u_dut_w20 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .vec_i(vec[19:0]),
    .valid_o(v20), .sum_o(s20));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic drive(input logic [127:0] w);
    item_t it;
    @(negedge clk);
    vld = 1'b1;
    vec = w;
    it.cnt = $countones(w);      it.due = cyc + LAT128; q128.push_back(it);
    it.cnt = $countones(w[7:0]); it.due = cyc + LAT8;   q8.push_back(it);
    it.cnt = $countones(w[19:0]); it.due = cyc + LAT20; q20.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vld = 1'b0;
      vec = {$urandom, $urandom, $urandom, $urandom};
    end
  endtask

  task automatic mon(ref item_t q[$], input logic v, input int s, input string tag);
    item_t it;
    if (v) begin
      if (q.size() == 0) begin
        check(1'b0, {tag, " R3 unexpected valid_o"}, 1, 0);
      end else begin
        it = q.pop_front();
        check(it.due == cyc, {tag, " R2/R4 result cycle"}, cyc, it.due);
        check(s == it.cnt, {tag, " R1/R5 popcount"}, s, it.cnt);
      end
    end else if (q.size() != 0 && q[0].due <= cyc) begin
      it = q.pop_front();
      check(1'b0, {tag, " R3 missing valid_o"}, 0, 1);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      mon(q128, v128, int'(s128), "w128");
      mon(q8,   v8,   int'(s8),   "w8");
      mon(q20,  v20,  int'(s20),  "w20");
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    vec = {$urandom, $urandom, $urandom, $urandom};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R6: reset state
    check(v128 == 1'b0 && v8 == 1'b0 && v20 == 1'b0, "R6 valid_o in reset", int'(v128), 0);
    check(s128 == '0 && s8 == '0 && s20 == '0, "R6 sum_o in reset", int'(s128), 0);
    // R7: output widths
    check($bits(s128) == 8 && $bits(s8) == 4 && $bits(s20) == 5, "R7 sum width",
          $bits(s128), 8);
    vld = 1'b1;
    repeat (2) @(negedge clk);
    check(v128 == 1'b0 && s128 == '0, "R6 valid_i ignored in reset", int'(s128), 0);
    vld = 1'b0;
    rst_n = 1'b1;
    idle(2);

    // R5: boundary patterns
    drive('0);
    drive('1);
    idle(4);
    drive({1'b1, 127'b0});
    drive(128'h8_0080);           // bit 19 and bit 7
    drive({64{2'b10}});
    drive({64{2'b01}});
    idle(5);

    // R4: back-to-back random words
    for (int i = 0; i < 60; i++) drive({$urandom, $urandom, $urandom, $urandom});
    // sparse words with gaps
    for (int i = 0; i < 20; i++) begin
      drive({$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom});
      idle(i % 3);
    end
    drive('1);
    drive('1);
    idle(8);

    check(q128.size() == 0, "R3 w128 all results delivered", q128.size(), 0);
    check(q8.size() == 0,   "R3 w8 all results delivered",   q8.size(),   0);
    check(q20.size() == 0,  "R3 w20 all results delivered",  q20.size(),  0);
    check(!v128 && !v8 && !v20, "R3 valid_o low when idle", int'(v128), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule